// File: doc/BRIEF.md
# K/N Parameter Transform Selector

This block forms the byte that a microprogrammed processor writes into its K or N parameter register. It chooses among eight byte-wide sources: fields of the latched macro-instruction, fields of a low-delta latch, the low byte of a CPU selector, and the low byte of the microinstruction register. Normally the choice comes from the three low-order bits of the microinstruction low byte. Several conditions override that code. A clear command forces zeros. Sequential-address mode forces the microinstruction byte. A deasserted qualifier forces the macro-decode source. The macro-decode command always loads that same source into K.

The result is registered. The byte and its write strobes appear together one clock after the command. There is no back-pressure: the K and N registers accept a write on every cycle. Each strobe is therefore a one-cycle pulse with no ready signal. The byte holds its value on cycles with no command.

Top module: `knx_xform`

## Requirements
- R1: While `rst_n` is low, `kn_data`, `k_load` and `n_load` are all zero.
- R2: A command on the inputs produces its `kn_data` and strobe at the following rising edge. The strobe lasts one cycle unless the command is repeated.
- R3: When there is no clear, no macro-decode, `mir_mode` is not 2'b11 and `mir_qual` is 1, `mir_lo[2:0]` selects the source:
  - 0: `sel_s2_lo`
  - 1: {3'b0, `delta_lo[4:0]`}
  - 2: {4'b0, `macro_ir[7:4]`}
  - 3: {4'b0, `macro_ir[11:8]`}
  - 4: {4'b0, `delta_lo[7:4]`}
  - 6: `mir_lo`
  - 7: {`macro_ir[15:12]`, `macro_ir[3:0]`}
- R4: Source 5 is unassigned and yields 8'h00.
- R5: Clear has the highest priority and forces `kn_data` to 8'h00. `cmd_clr_k` raises `k_load`; `cmd_clr_n` or `cmd_clr_np` raises `n_load`.
- R6: When `mir_mode` is 2'b11 (sequential-address mode), source 6 is used whatever `mir_lo[2:0]` and `mir_qual` are.
- R7: When not in sequential-address mode, `mir_qual` = 0 forces source 7.
- R8: `cmd_mdec` loads source 7 into K. It raises `k_load`, holds `n_load` low, and overrides sequential mode and the qualifier, but not a clear.
- R9: In a cycle with no load, clear or macro-decode command, both strobes are low at the next edge and `kn_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| macro_ir | input | 16 | Latched macro-instruction |
| delta_lo | input | 8 | Low-delta latch |
| sel_s2_lo | input | 8 | Low byte of the CPU selector |
| mir_lo | input | 8 | Microinstruction low byte; bits 2:0 are the select code |
| mir_mode | input | 2 | Microinstruction mode bits; 2'b11 means sequential-address mode |
| mir_qual | input | 1 | Secondary microinstruction qualifier |
| cmd_ld_k | input | 1 | Load K from the selected source |
| cmd_ld_n | input | 1 | Load N from the selected source |
| cmd_clr_k | input | 1 | Clear K |
| cmd_clr_n | input | 1 | Clear N |
| cmd_clr_np | input | 1 | Clear N and page |
| cmd_mdec | input | 1 | Macro-decode transform (loads K from source 7) |
| kn_data | output | 8 | Byte for the K or N register |
| k_load | output | 1 | Write strobe for K |
| n_load | output | 1 | Write strobe for N |

## Verification
Every result of this block is due exactly one rising edge after its command. Inputs are driven on the falling edge. The byte and strobes are sampled on the next falling edge, half a period after the register has captured. The bench then removes the commands and samples again one full cycle later, to confirm that the strobe has dropped and the byte is held. Priority cases put two conflicting controls in the same cycle, so the winner is visible in that single sampled result.

// File: rtl/knx_pkg.sv
package knx_pkg;
  localparam int unsigned KNX_DW   = 8;
  localparam int unsigned KNX_SELW = 3;
  localparam int unsigned KNX_NSRC = 1 << KNX_SELW;

  typedef enum logic [KNX_SELW-1:0] {
    SRC_SELBYTE = 3'd0,
    SRC_DLT_LO  = 3'd1,
    SRC_IR_MID  = 3'd2,
    SRC_IR_HI   = 3'd3,
    SRC_DLT_HI  = 3'd4,
    SRC_UNUSED  = 3'd5,
    SRC_MIRBYTE = 3'd6,
    SRC_MDEC    = 3'd7
  } knx_src_e;

  typedef struct packed {
    logic           zero;
    logic           k_wr;
    logic           n_wr;
    knx_src_e       src;
  } knx_ctl_t;
endpackage

// File: rtl/knx_src_bank.sv
module knx_src_bank
  import knx_pkg::*;
#(
  parameter int unsigned DW   = KNX_DW,
  parameter int unsigned MW   = 16,
  parameter int unsigned NSRC = KNX_NSRC
) (
  input  logic [MW-1:0]          macro_ir,
  input  logic [DW-1:0]          delta_lo,
  input  logic [DW-1:0]          sel_s2_lo,
  input  logic [DW-1:0]          mir_lo,
  output logic [NSRC-1:0][DW-1:0] src
);
  localparam int unsigned NIB = DW / 2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == SRC_SELBYTE) begin : g_s0
      assign src[g] = sel_s2_lo;
    end else if (g == SRC_DLT_LO) begin : g_s1
      assign src[g] = {3'b000, delta_lo[4:0]};
    end else if (g == SRC_IR_MID) begin : g_s2
      assign src[g] = {{NIB{1'b0}}, macro_ir[7:4]};
    end else if (g == SRC_IR_HI) begin : g_s3
      assign src[g] = {{NIB{1'b0}}, macro_ir[11:8]};
    end else if (g == SRC_DLT_HI) begin : g_s4
      assign src[g] = {{NIB{1'b0}}, delta_lo[7:4]};
    end else if (g == SRC_MIRBYTE) begin : g_s6
      assign src[g] = mir_lo;
    end else if (g == SRC_MDEC) begin : g_s7
      assign src[g] = {macro_ir[15:12], macro_ir[3:0]};
    end else begin : g_none
      assign src[g] = '0;
    end
  end
endmodule

// File: rtl/knx_sel_ctl.sv
module knx_sel_ctl
  import knx_pkg::*;
(
  input  logic [KNX_SELW-1:0] sel_code,
  input  logic [1:0]          mir_mode,
  input  logic                mir_qual,
  input  logic                cmd_ld_k,
  input  logic                cmd_ld_n,
  input  logic                cmd_clr_k,
  input  logic                cmd_clr_n,
  input  logic                cmd_clr_np,
  input  logic                cmd_mdec,
  output knx_ctl_t            ctl
);
  logic seq_mode;
  logic any_clr;

  assign seq_mode = &mir_mode;
  assign any_clr  = cmd_clr_k | cmd_clr_n | cmd_clr_np;

  always_comb begin
    ctl.zero = 1'b0;
    ctl.src  = knx_src_e'(sel_code);
    if (any_clr) begin
      ctl.zero = 1'b1;
    end else if (cmd_mdec) begin
      ctl.src = SRC_MDEC;
    end else if (seq_mode) begin
      ctl.src = SRC_MIRBYTE;
    end else if (!mir_qual) begin
      ctl.src = SRC_MDEC;
    end
    ctl.k_wr = cmd_ld_k | cmd_clr_k | (cmd_mdec & ~any_clr);
    ctl.n_wr = (cmd_ld_n & ~cmd_mdec) | cmd_clr_n | cmd_clr_np;
  end
endmodule

// File: rtl/knx_mux.sv
module knx_mux
  import knx_pkg::*;
#(
  parameter int unsigned DW   = KNX_DW,
  parameter int unsigned NSRC = KNX_NSRC
) (
  input  logic [NSRC-1:0][DW-1:0] src,
  input  knx_ctl_t                ctl,
  output logic [DW-1:0]           dout
);
  logic [NSRC-1:0] hot;

  for (genvar g = 0; g < NSRC; g++) begin : g_hot
    assign hot[g] = (ctl.src == knx_src_e'(g)) & ~ctl.zero;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NSRC; i++) begin
      dout = dout | (src[i] & {DW{hot[i]}});
    end
  end
endmodule

// File: rtl/knx_xform.sv
module knx_xform
  import knx_pkg::*;
#(
  parameter int unsigned DW = KNX_DW,
  parameter int unsigned MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] macro_ir,
  input  logic [DW-1:0] delta_lo,
  input  logic [DW-1:0] sel_s2_lo,
  input  logic [DW-1:0] mir_lo,
  input  logic [1:0]    mir_mode,
  input  logic          mir_qual,
  input  logic          cmd_ld_k,
  input  logic          cmd_ld_n,
  input  logic          cmd_clr_k,
  input  logic          cmd_clr_n,
  input  logic          cmd_clr_np,
  input  logic          cmd_mdec,
  output logic [DW-1:0] kn_data,
  output logic          k_load,
  output logic          n_load
);
  localparam int unsigned NSRC = KNX_NSRC;

  logic [NSRC-1:0][DW-1:0] src;
  knx_ctl_t                ctl;
  logic [DW-1:0]           sel_byte;

  knx_src_bank #(.DW(DW), .MW(MW), .NSRC(NSRC)) u_bank (
    .macro_ir (macro_ir),
    .delta_lo (delta_lo),
    .sel_s2_lo(sel_s2_lo),
    .mir_lo   (mir_lo),
    .src      (src)
  );

  knx_sel_ctl u_ctl (
    .sel_code  (mir_lo[KNX_SELW-1:0]),
    .mir_mode  (mir_mode),
    .mir_qual  (mir_qual),
    .cmd_ld_k  (cmd_ld_k),
    .cmd_ld_n  (cmd_ld_n),
    .cmd_clr_k (cmd_clr_k),
    .cmd_clr_n (cmd_clr_n),
    .cmd_clr_np(cmd_clr_np),
    .cmd_mdec  (cmd_mdec),
    .ctl       (ctl)
  );

  knx_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .src (src),
    .ctl (ctl),
    .dout(sel_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kn_data <= '0;
      k_load  <= 1'b0;
      n_load  <= 1'b0;
    end else begin
      k_load <= ctl.k_wr;
      n_load <= ctl.n_wr;
      if (ctl.k_wr | ctl.n_wr) begin
        kn_data <= sel_byte;
      end
    end
  end
endmodule

// File: rtl/knx_xform_chk.sv
module knx_xform_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned MW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] macro_ir,
  input logic [DW-1:0] mir_lo,
  input logic [1:0]    mir_mode,
  input logic          mir_qual,
  input logic          cmd_ld_k,
  input logic          cmd_ld_n,
  input logic          cmd_clr_k,
  input logic          cmd_clr_n,
  input logic          cmd_clr_np,
  input logic          cmd_mdec,
  input logic [DW-1:0] kn_data,
  input logic          k_load,
  input logic          n_load
);
  logic primed;
  logic clr_any, ld_any;

  assign clr_any = cmd_clr_k | cmd_clr_n | cmd_clr_np;
  assign ld_any  = cmd_ld_k | cmd_ld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (kn_data == '0 && !k_load && !n_load); // R1
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    primed && clr_any |=> kn_data == '0); // R5

  AST_SEQ_MIRBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ld_any && !clr_any && !cmd_mdec && mir_mode == 2'b11
    |=> kn_data == $past(mir_lo)); // R6

  AST_QUAL_MDEC: assert property (@(posedge clk) disable iff (!rst_n)
    primed && ld_any && !clr_any && !cmd_mdec && mir_mode != 2'b11 && !mir_qual
    |=> kn_data == {$past(macro_ir[15:12]), $past(macro_ir[3:0])}); // R7

  AST_MDEC_K_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    primed && cmd_mdec && !clr_any |=> k_load && !n_load); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !ld_any && !clr_any && !cmd_mdec
    |=> !k_load && !n_load && $stable(kn_data)); // R9
endmodule

bind knx_xform knx_xform_chk #(.DW(DW), .MW(MW)) u_knx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .macro_ir  (macro_ir),
  .mir_lo    (mir_lo),
  .mir_mode  (mir_mode),
  .mir_qual  (mir_qual),
  .cmd_ld_k  (cmd_ld_k),
  .cmd_ld_n  (cmd_ld_n),
  .cmd_clr_k (cmd_clr_k),
  .cmd_clr_n (cmd_clr_n),
  .cmd_clr_np(cmd_clr_np),
  .cmd_mdec  (cmd_mdec),
  .kn_data   (kn_data),
  .k_load    (k_load),
  .n_load    (n_load)
);

// File: tb/knx_xform_bench.sv
`timescale 1ns/1ps
module knx_xform_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] macro_ir = '0;
  logic [7:0]  delta_lo = '0, sel_s2_lo = '0, mir_lo = '0;
  logic [1:0]  mir_mode = '0;
  logic        mir_qual = 1'b1;
  logic        cmd_ld_k = 0, cmd_ld_n = 0, cmd_clr_k = 0, cmd_clr_n = 0;
  logic        cmd_clr_np = 0, cmd_mdec = 0;
  logic [7:0]  kn_data;
  logic        k_load, n_load;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  knx_xform u_knx_xform (
    .clk(clk), .rst_n(rst_n), .macro_ir(macro_ir), .delta_lo(delta_lo),
    .sel_s2_lo(sel_s2_lo), .mir_lo(mir_lo), .mir_mode(mir_mode),
    .mir_qual(mir_qual), .cmd_ld_k(cmd_ld_k), .cmd_ld_n(cmd_ld_n),
    .cmd_clr_k(cmd_clr_k), .cmd_clr_n(cmd_clr_n), .cmd_clr_np(cmd_clr_np),
    .cmd_mdec(cmd_mdec), .kn_data(kn_data), .k_load(k_load), .n_load(n_load)
  );

  function automatic logic [7:0] exp_src(input int code);
    case (code)
      0: return sel_s2_lo;
      1: return {3'b000, delta_lo[4:0]};
      2: return {4'h0, macro_ir[7:4]};
      3: return {4'h0, macro_ir[11:8]};
      4: return {4'h0, delta_lo[7:4]};
      6: return mir_lo;
      7: return {macro_ir[15:12], macro_ir[3:0]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cmds();
    cmd_ld_k = 0; cmd_ld_n = 0; cmd_clr_k = 0; cmd_clr_n = 0;
    cmd_clr_np = 0; cmd_mdec = 0;
  endtask

  task automatic t_reset();
    check("R1", {kn_data, k_load, n_load}, 10'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", {kn_data, k_load, n_load}, 10'h0);
  endtask

  task automatic t_codes();
    macro_ir = 16'hA5C3; delta_lo = 8'h9E; sel_s2_lo = 8'h6B;
    for (int c = 0; c < 8; c++) begin
      logic [7:0] e;
      mir_lo = 8'hF8 | 8'(c); mir_mode = 2'b01; mir_qual = 1;
      e = exp_src(c);
      cmd_ld_n = 1;
      @(negedge clk); idle_cmds();
      check(c == 5 ? "R4" : "R3", {kn_data, k_load, n_load}, {e, 2'b01});
    end
  endtask

  task automatic t_pulse();
    mir_lo = 8'h00; sel_s2_lo = 8'h3C; cmd_ld_k = 1;
    @(negedge clk); idle_cmds();
    check("R2", {kn_data, k_load, n_load}, {8'h3C, 2'b10});
    sel_s2_lo = 8'h77;
    @(negedge clk);
    check("R2", {1'b0, k_load, 8'h0}, 10'h0);
    check("R9", {kn_data, k_load, n_load}, {8'h3C, 2'b00});
  endtask

  task automatic t_seq();
    mir_mode = 2'b11; mir_qual = 0; mir_lo = 8'h52; cmd_ld_k = 1;
    @(negedge clk); idle_cmds();
    check("R6", {kn_data, k_load, n_load}, {8'h52, 2'b10});
  endtask

  task automatic t_qual();
    mir_mode = 2'b10; mir_qual = 0; mir_lo = 8'h03; macro_ir = 16'h4E19;
    cmd_ld_n = 1;
    @(negedge clk); idle_cmds();
    check("R7", {kn_data, k_load, n_load}, {8'h49, 2'b01});
    mir_qual = 1;
  endtask

  task automatic t_mdec();
    mir_mode = 2'b11; mir_lo = 8'hE0; macro_ir = 16'h0C70;
    cmd_mdec = 1; cmd_ld_n = 1;
    @(negedge clk); idle_cmds();
    check("R8", {kn_data, k_load, n_load}, {8'h00, 2'b10});
    macro_ir = 16'hB2F6; mir_mode = 2'b00; mir_lo = 8'h00; cmd_mdec = 1;
    @(negedge clk); idle_cmds();
    check("R8", {kn_data, k_load, n_load}, {8'hB6, 2'b10});
  endtask

  task automatic t_clear();
    cmd_clr_k = 1; cmd_mdec = 1; mir_lo = 8'h06;
    @(negedge clk); idle_cmds();
    check("R5", {kn_data, k_load, n_load}, {8'h00, 2'b10});
    sel_s2_lo = 8'hAA; mir_lo = 8'h00; cmd_ld_n = 1;
    @(negedge clk); idle_cmds();
    check("R3", {kn_data, k_load, n_load}, {8'hAA, 2'b01});
    cmd_clr_np = 1; cmd_ld_n = 1;
    @(negedge clk); idle_cmds();
    check("R5", {kn_data, k_load, n_load}, {8'h00, 2'b01});
    sel_s2_lo = 8'h11; cmd_ld_n = 1;
    @(negedge clk); cmd_ld_n = 0; cmd_clr_n = 1;
    @(negedge clk); idle_cmds();
    check("R5", {kn_data, k_load, n_load}, {8'h00, 2'b01});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    t_codes();
    t_pulse();
    t_seq();
    t_qual();
    t_mdec();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule